// File: doc/BRIEF.md
# Addressable Cascadable Shift Register

This block is a serial delay line for single-bit data. It is built from a chain of fixed-length shift units, 16 stages each by default. Each enabled rising clock edge moves every stored bit one stage further along the line. A new bit enters at the head of the line.

A run-time tap address selects which stage drives the data output, so the delay can be retuned without touching the stored data. The low address bits choose a stage inside a unit, and the remaining high bits choose the unit. A separate cascade output always presents the final stage of the whole line, so a further line can be appended outside the block.

Typical uses are alignment delays and pipeline balancing, where the required latency is only known at run time.

Top module: `srl_chain`

## Requirements
- R1: While reset is low, and after it is released, every stage reads zero: `dout` is 0 for every address and `cascade_out` is 0. This also holds when reset is applied in the middle of traffic.
- R2: On a rising edge with `ce` low, nothing moves. `dout` for every address and `cascade_out` keep their values whatever `din` does.
- R3: With `addr` = A, a bit presented on `din` at an enabled edge appears on `dout` after exactly A+1 enabled edges. The delay therefore ranges from 1 to UNITS*DEPTH cycles.
- R4: A change of `addr` changes `dout` without any clock edge, in the same cycle.
- R5: `cascade_out` carries the bit that entered UNITS*DEPTH enabled edges earlier, whatever `addr` is. It equals `dout` when `addr` = UNITS*DEPTH-1.
- R6: Units are contiguous. `addr[3:0]` picks the stage within a unit and `addr[AW-1:4]` picks the unit, so addresses 15 and 16 give consecutive delays of 16 and 17. The last stage of each unit feeds the first stage of the next.
- R7: When `addr[3:0]` = 15, `dout` shows the last stage of the selected unit, which is the same bit that unit passes on to the next unit.
- R8: Only enabled edges count toward the delay. Disabled cycles placed between enabled ones neither drop bits nor insert extra ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear of all stages |
| ce | input | 1 | Shift enable, sampled on the rising edge |
| din | input | 1 | Serial data into stage 0 |
| addr | input | AW (7 by default) | Tap address; delay is addr+1 |
| dout | output | 1 | Bit held in the addressed stage |
| cascade_out | output | 1 | Bit held in the final stage of the line |

## Verification
A stage that holds a wrong bit stays invisible until the tap address points at it, or until the bit reaches the end of the line. For that reason the tests sweep the address across every stage between clock edges, so a corrupt stage shows on `dout` within the same cycle.

A missing or extra shift, or a broken link between two units, shifts the whole pattern. It shows as a mismatch on `cascade_out` within UNITS*DEPTH enabled edges, and at a boundary address (15/16) within 17 edges. A single-bit impulse gives the exact delay at chosen addresses, so an off-by-one error in the tap decode shows up as a wrong arrival cycle.

// File: rtl/srl_pkg.sv
package srl_pkg;

  localparam int SRL_DEPTH_DEF = 16;
  localparam int SRL_UNITS_DEF = 8;

  // Width of an address spanning the complete line of units*depth stages.
  function automatic int addr_bits(int depth, int units);
    return $clog2(depth * units);
  endfunction

  // Width of the field choosing one unit; at least one bit wide.
  function automatic int unit_bits(int units);
    return (units > 1) ? $clog2(units) : 1;
  endfunction

endpackage

// File: rtl/srl_unit.sv
module srl_unit #(
  parameter int DEPTH = 16,
  localparam int SW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          d_in,
  input  logic [SW-1:0] tap_sel,
  output logic          tap_out,
  output logic          head_out,
  output logic          casc_out
);

  logic [DEPTH-1:0] q;

  // Stage 0 takes the new bit; stage k takes stage k-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ce) begin
      q <= {q[DEPTH-2:0], d_in};
    end
  end

  // The tap is read without a register, so an address change is seen at once.
  always_comb tap_out = q[tap_sel];

  assign head_out = q[0];
  assign casc_out = q[DEPTH-1];

endmodule

// File: rtl/srl_sel.sv
module srl_sel #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  in_vec,
  input  logic [IW-1:0] idx,
  output logic          out_bit
);

  generate
    if (N == 1) begin : g_single
      logic unused_idx;
      assign unused_idx = ^idx;
      assign out_bit    = in_vec[0];
    end else begin : g_multi
      always_comb out_bit = in_vec[idx];
    end
  endgenerate

endmodule

// File: rtl/srl_chain.sv
module srl_chain
  import srl_pkg::*;
#(
  parameter int DEPTH = SRL_DEPTH_DEF,
  parameter int UNITS = SRL_UNITS_DEF,
  localparam int AW = addr_bits(DEPTH, UNITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          din,
  input  logic [AW-1:0] addr,
  output logic          dout,
  output logic          cascade_out
);

  localparam int SW = $clog2(DEPTH);
  localparam int UW = unit_bits(UNITS);

  // The low address bits pick a stage inside a unit.
  function automatic logic [SW-1:0] tap_of(logic [AW-1:0] a);
    return a[SW-1:0];
  endfunction

  // The high address bits pick the unit.
  function automatic logic [UW-1:0] unit_of(logic [AW-1:0] a);
    return UW'(a >> SW);
  endfunction

  logic [UNITS-1:0] unit_in;
  logic [UNITS-1:0] unit_tap;
  logic [UNITS-1:0] unit_head;
  logic [UNITS-1:0] unit_casc;
  logic [SW-1:0]    tap_idx;
  logic [UW-1:0]    unit_idx;

  assign tap_idx  = tap_of(addr);
  assign unit_idx = unit_of(addr);

  generate
    for (genvar g = 0; g < UNITS; g++) begin : g_unit
      if (g == 0) begin : g_first
        assign unit_in[g] = din;
      end else begin : g_next
        assign unit_in[g] = unit_casc[g-1];
      end

      srl_unit #(.DEPTH(DEPTH)) u_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .d_in     (unit_in[g]),
        .tap_sel  (tap_idx),
        .tap_out  (unit_tap[g]),
        .head_out (unit_head[g]),
        .casc_out (unit_casc[g])
      );
    end
  endgenerate

  srl_sel #(.N(UNITS), .IW(UW)) u_sel (
    .in_vec  (unit_tap),
    .idx     (unit_idx),
    .out_bit (dout)
  );

  assign cascade_out = unit_casc[UNITS-1];

endmodule

// File: rtl/srl_chain_chk.sv
module srl_chain_chk #(
  parameter int DEPTH = 16,
  parameter int UNITS = 8,
  localparam int SW = $clog2(DEPTH),
  localparam int AW = $clog2(DEPTH * UNITS),
  localparam int UW = (UNITS > 1) ? $clog2(UNITS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce,
  input logic             din,
  input logic [AW-1:0]    addr,
  input logic             dout,
  input logic             cascade_out,
  input logic [UNITS-1:0] unit_head,
  input logic [UNITS-1:0] unit_casc
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (cascade_out == 1'b0 && unit_head == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(cascade_out) && $stable(unit_head)));

  // R3
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (unit_head[0] == $past(din)));

  // R5
  end_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(DEPTH * UNITS - 1)) |-> (dout == cascade_out));

  // R7
  last_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[SW-1:0] == SW'(DEPTH - 1)) |-> (dout == unit_casc[UW'(addr >> SW)]));

  generate
    if (UNITS > 1) begin : g_link
      // R6
      link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> (unit_head[UNITS-1:1] == $past(unit_casc[UNITS-2:0])));
    end
  endgenerate

endmodule

bind srl_chain srl_chain_chk #(.DEPTH(DEPTH), .UNITS(UNITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce          (ce),
  .din         (din),
  .addr        (addr),
  .dout        (dout),
  .cascade_out (cascade_out),
  .unit_head   (unit_head),
  .unit_casc   (unit_casc)
);

// File: tb/srl_chain_tb.sv
`timescale 1ns/1ps
module srl_chain_tb;

  localparam int TOTAL = 128;
  localparam int AW    = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce;
  logic          din;
  logic [AW-1:0] addr;
  logic          dout;
  logic          cascade_out;

  logic [TOTAL-1:0] hist;   // hist[k]: bit that entered k+1 enabled edges ago
  logic [15:0]      lf;
  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  srl_chain u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din(din),
    .addr(addr), .dout(dout), .cascade_out(cascade_out)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b (addr=%0d)", tag, act, exp, addr);
    end
  endtask

  task automatic tick(logic b_ce, logic b_din);
    @(negedge clk);
    ce  = b_ce;
    din = b_din;
    @(posedge clk);
    if (b_ce) hist = {hist[TOTAL-2:0], b_din};
    #2;
  endtask

  task automatic look(logic [AW-1:0] a);
    addr = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    ce = 1'b0;
    rst_n = 1'b0;
    hist = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
  endtask

  function automatic logic [15:0] lf_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // R1: all stages clear, both at start and after traffic
  task automatic t_reset();
    do_reset();
    for (int a = 0; a < TOTAL; a++) begin
      look(AW'(a));
      chk("R1 dout after reset", dout, 1'b0);
    end
    chk("R1 cascade after reset", cascade_out, 1'b0);
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b1);
    do_reset();
    for (int a = 0; a < TOTAL; a += 9) begin
      look(AW'(a));
      chk("R1 dout after mid-run reset", dout, 1'b0);
    end
    chk("R1 cascade after mid-run reset", cascade_out, 1'b0);
  endtask

  // R3 / R6 / R7 / R5: single 1 arrives exactly after addr+1 enabled edges
  task automatic t_impulse(logic [AW-1:0] a);
    do_reset();
    look(a);
    tick(1'b1, 1'b1);
    for (int n = 1; n <= int'(a) + 2; n++) begin
      if (n > 1) tick(1'b1, 1'b0);
      chk((a[3:0] == 4'd15) ? "R7 impulse at unit end" : "R3 impulse delay",
          dout, (n == int'(a) + 1));
      if (int'(a) == TOTAL - 1)
        chk("R5 cascade impulse", cascade_out, (n == TOTAL));
    end
  endtask

  // R3 / R5 / R4: pseudo-random stream with an address moving every cycle
  task automatic t_stream();
    do_reset();
    for (int i = 0; i < 300; i++) begin
      lf = lf_next(lf);
      tick(1'b1, lf[0]);
      look(AW'((i * 37) % TOTAL));
      chk("R3 stream tap", dout, hist[addr]);
      chk("R5 stream cascade", cascade_out, hist[TOTAL-1]);
    end
  endtask

  // R2: disabled edges change nothing while din toggles
  task automatic t_hold();
    logic [TOTAL-1:0] snap;
    snap = hist;
    for (int i = 0; i < 12; i++) begin
      tick(1'b0, i[0]);
      for (int a = i; a < TOTAL; a += 23) begin
        look(AW'(a));
        chk("R2 hold tap", dout, snap[a]);
      end
      chk("R2 hold cascade", cascade_out, snap[TOTAL-1]);
    end
  endtask

  // R4: sweep the address with no shifting, each read in the same cycle
  task automatic t_addr_async();
    @(negedge clk);
    ce = 1'b0;
    for (int a = 0; a < TOTAL; a++) begin
      addr = AW'(a);
      #0.05;
      chk("R4 tap follows address", dout, hist[a]);
    end
  endtask

  // R8: enabled edges interleaved with disabled ones
  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 260; i++) begin
      lf = lf_next(lf);
      tick(lf[3] | lf[7], lf[0]);
      look(AW'(16 + (i % 3)));
      chk("R8 gapped tap", dout, hist[addr]);
      chk("R8 gapped cascade", cascade_out, hist[TOTAL-1]);
    end
  endtask

  initial begin
    rst_n = 1'b0; ce = 1'b0; din = 1'b0; addr = '0;
    hist = '0; lf = 16'hACE1;
    t_reset();
    t_impulse(7'd0);
    t_impulse(7'd1);
    t_impulse(7'd15);
    t_impulse(7'd16);
    t_impulse(7'd47);
    t_impulse(7'd127);
    t_stream();
    t_hold();
    t_addr_async();
    t_gaps();
    t_addr_async();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule